// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a master for the two-wire MDIO management bus. Software controls it through four 32-bit registers: a configuration/status word, a control word, an extended-address word and a data word. The configuration word picks the frame format, either the short one (Clause 22) or the extended one (Clause 45), and sets the MDC clock divider. The control word carries the PHY port number and a 5-bit second address field. In the short format that field is the register number. In the extended format it is the device number.

Each frame is started by a single register write. In the extended format, writing the extended-address word sends an address frame. Writing the data word sends a write frame. Writing the control word with its read bit set sends a read frame. MDC runs only while a frame is in flight. The master drives MDIO on the falling edge of MDC and samples it on the rising edge. It uses a separate output, output-enable and input, and releases the line for the read turnaround and the read data.

Software polls the busy flag in the status word before each access. After a read it checks the error flag.

Top module: `mdio_master_regs`

## Requirements
- R1: After reset the configuration word reads 0 (busy bit 0 clear, error bit 1 clear, format bit 2 clear, divider field [25:16] zero), data-word bit 31 is clear, and mdc and mdio_oe are low.
- R2: While a frame is active, MDC has a period of 2×D system clocks, where D is the divider field. With D = 0, MDC stays low and the frame does not advance.
- R3: Every frame is 64 MDC cycles long: 32 ones, then start (2 bits), op (2), port (5), second address (5), turnaround (2) and 16 payload bits, most significant bit first.
- R4: Writing the data word (offset 3) with the format bit clear sends start 01, op 01, the control-word port [9:5] and register [4:0], turnaround 10 and data[15:0].
- R5: Writing the extended-address word (offset 2) with the format bit set sends start 00, op 00, turnaround 10 and address[15:0]. With the format bit clear, the write only stores the value, which reads back at offset 2, and no frame is sent.
- R6: Writing the data word with the format bit set sends start 00, op 01.
- R7: Writing the control word (offset 1) with bit 15 set sends a read frame: start 01/op 10 in the short format, start 00/op 11 in the extended format. mdio_oe drops from bit 46 onward. The 16 bits sampled in positions 48–63 appear in data-word bits [15:0].
- R8: Data-word bit 31 is set by a write or read launch and clears when that frame ends. An address frame leaves it clear.
- R9: Configuration-word bit 0 is high while any frame is active.
- R10: Bit 1 of the configuration word is set at the end of a read when MDIO was not 0 in turnaround position 47. In that case the data word reads 0xFFFF. Every launch clears the bit.
- R11: Any register write made while bit 0 is set is ignored: stored values are unchanged and the frame in flight is not disturbed.
- R12: mdio_o changes only when MDC falls or when a frame launches, never while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word offset: 0 config/status, 1 control, 2 extended address, 3 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value |

## Verification
Address, write and read frames are issued in both formats, with random ports, address fields, payloads and dividers. The whole 64-bit line pattern is captured at every MDC rise, so a wrong start, op, turnaround or bit order each shows up as a distinct mismatch. Reads run once with a responding device and once with no device, which separates the captured data path from the error path. Directed cases cover the address write in short format, writes made while busy, and a zero divider.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {FR_ADDR = 2'd0, FR_WRITE = 2'd1, FR_READ = 2'd2} frame_kind_e;

  localparam logic [1:0] ST_SHORT = 2'b01;
  localparam logic [1:0] ST_EXT   = 2'b00;
  localparam logic [1:0] OP_ADDR  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_RD_S  = 2'b10;
  localparam logic [1:0] OP_RD_E  = 2'b11;

  localparam logic [1:0] OFS_CFG  = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_ADDR = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  always_comb begin
    hit     = run && (div != '0) && (cnt == div - 1'b1);
    rise_ev = hit && !mdc;
    fall_ev = hit && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (div != '0) begin
      if (hit) begin
        cnt <= '0;
        mdc <= !mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_MDC_HELD: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !mdc); // R2
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc); // R1
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int PHY_W   = 5,
  parameter int DEV_W   = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_ext,
  input  frame_kind_e       kind,
  input  logic [PHY_W-1:0]  port,
  input  logic [DEV_W-1:0]  dev,
  input  logic [DATA_W-1:0] payload,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdo,
  output logic              oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fail
);
  localparam int HDR_LEN   = PRE_LEN + 4 + PHY_W + DEV_W;
  localparam int FRAME_LEN = HDR_LEN + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(HDR_LEN - 1);
  localparam logic [IDX_W-1:0] HDR_IDX  = IDX_W'(HDR_LEN);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(HDR_LEN + 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(HDR_LEN + 2);

  logic [FRAME_LEN-1:0] frame_w, shreg;
  logic [IDX_W-1:0]     idx;
  logic [1:0]           st_w, op_w, ta_w;
  logic [DATA_W-1:0]    pay_w;
  logic                 rd_q, ta_ok;

  always_comb begin
    st_w = is_ext ? ST_EXT : ST_SHORT;
    case (kind)
      FR_ADDR:  op_w = OP_ADDR;
      FR_WRITE: op_w = OP_WRITE;
      FR_READ:  op_w = is_ext ? OP_RD_E : OP_RD_S;
      default:  op_w = OP_WRITE;
    endcase
    ta_w    = (kind == FR_READ) ? 2'b11 : 2'b10;
    pay_w   = (kind == FR_READ) ? '1 : payload;
    frame_w = {{PRE_LEN{1'b1}}, st_w, op_w, port, dev, ta_w, pay_w};
  end

  assign rd_fail = !ta_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      mdo     <= 1'b0;
      oe      <= 1'b0;
      done    <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      ta_ok   <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        shreg  <= frame_w;
        idx    <= '0;
        active <= 1'b1;
        mdo    <= frame_w[FRAME_LEN-1];
        oe     <= 1'b1;
        rd_q   <= (kind == FR_READ);
        ta_ok  <= 1'b0;
      end else if (active) begin
        if (rise_ev && rd_q) begin
          if (idx == TA2_IDX) ta_ok <= !mdio_i;
          if (idx >= DAT_IDX) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        end
        if (fall_ev) begin
          if (idx == LAST_IDX) begin
            active <= 1'b0;
            oe     <= 1'b0;
            mdo    <= 1'b0;
            done   <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            shreg <= shreg << 1;
            mdo   <= shreg[FRAME_LEN-2];
            oe    <= !(rd_q && idx >= REL_IDX);
          end
        end
      end
    end
  end

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |-> !oe); // R1
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (active && rd_q && idx >= HDR_IDX) |-> !oe); // R7
  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdo) |-> $past(fall_ev || start)); // R12
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    done |-> !active); // R9
endmodule

// File: rtl/mdio_master_regs.sv
module mdio_master_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 10,
  parameter int DIV_RESET = 0,
  parameter int PRE_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PHY_W    = 5;
  localparam int DEV_W    = 5;
  localparam int DATA_W   = 16;
  localparam int DIV_LSB  = 16;
  localparam int PORT_LSB = DEV_W;
  localparam int RD_BIT   = 15;

  logic              enc_ext, data_busy, rd_err;
  logic [DIV_W-1:0]  div_q;
  logic [PHY_W-1:0]  port_q;
  logic [DEV_W-1:0]  dev_q;
  logic [15:0]       addr_q;
  logic [DATA_W-1:0] data_q;
  frame_kind_e       kind_q;

  logic              accept, launch, busy, rise_ev, fall_ev, eng_done, eng_fail;
  frame_kind_e       l_kind;
  logic [PHY_W-1:0]  l_port;
  logic [DEV_W-1:0]  l_dev;
  logic [DATA_W-1:0] l_pay, eng_rd;

  always_comb begin
    accept = reg_we && !busy;
    launch = 1'b0;
    l_kind = FR_WRITE;
    l_port = port_q;
    l_dev  = dev_q;
    l_pay  = reg_wdata[DATA_W-1:0];
    if (accept) begin
      case (reg_addr)
        OFS_CTRL: if (reg_wdata[RD_BIT]) begin
          launch = 1'b1;
          l_kind = FR_READ;
          l_port = reg_wdata[PORT_LSB +: PHY_W];
          l_dev  = reg_wdata[DEV_W-1:0];
        end
        OFS_ADDR: if (enc_ext) begin
          launch = 1'b1;
          l_kind = FR_ADDR;
        end
        OFS_DATA: launch = 1'b1;
        default:  launch = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_ext   <= 1'b0;
      div_q     <= DIV_W'(DIV_RESET);
      port_q    <= '0;
      dev_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      data_busy <= 1'b0;
      rd_err    <= 1'b0;
      kind_q    <= FR_WRITE;
    end else begin
      if (accept) begin
        case (reg_addr)
          OFS_CFG: begin
            enc_ext <= reg_wdata[2];
            div_q   <= reg_wdata[DIV_LSB +: DIV_W];
          end
          OFS_CTRL: begin
            port_q <= reg_wdata[PORT_LSB +: PHY_W];
            dev_q  <= reg_wdata[DEV_W-1:0];
          end
          OFS_ADDR: addr_q <= reg_wdata[15:0];
          default:  data_q <= reg_wdata[DATA_W-1:0];
        endcase
      end
      if (launch) begin
        kind_q    <= l_kind;
        rd_err    <= 1'b0;
        data_busy <= (l_kind != FR_ADDR);
      end
      if (eng_done) begin
        data_busy <= 1'b0;
        if (kind_q == FR_READ) begin
          rd_err <= eng_fail;
          data_q <= eng_fail ? '1 : eng_rd;
        end
      end
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .div(div_q),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .PHY_W(PHY_W), .DEV_W(DEV_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .start(launch), .is_ext(enc_ext), .kind(l_kind),
    .port(l_port), .dev(l_dev), .payload(l_pay),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
    .active(busy), .mdo(mdio_o), .oe(mdio_oe), .done(eng_done),
    .rd_data(eng_rd), .rd_fail(eng_fail)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CFG: begin
        reg_rdata[DIV_LSB +: DIV_W] = div_q;
        reg_rdata[2] = enc_ext;
        reg_rdata[1] = rd_err;
        reg_rdata[0] = busy;
      end
      OFS_CTRL: begin
        reg_rdata[PORT_LSB +: PHY_W] = port_q;
        reg_rdata[DEV_W-1:0]         = dev_q;
      end
      OFS_ADDR: reg_rdata[15:0] = addr_q;
      default: begin
        reg_rdata[31]         = data_busy;
        reg_rdata[DATA_W-1:0] = data_q;
      end
    endcase
  end

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we) |=> ($stable(div_q) && $stable(enc_ext) && $stable(data_q) && $stable(addr_q) && $stable(port_q))); // R11
  AST_DBUSY_COVERED: assert property (@(posedge clk) disable iff (rst)
    (data_busy && !eng_done) |-> busy); // R8
  AST_LAUNCH_ONE: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy); // R9
endmodule

// File: tb/sim_mdio_master_regs.sv
module sim_mdio_master_regs;
  logic        clk = 1'b0, rst = 1'b1, reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        resp_en = 1'b0, resp_bit = 1'b1;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = !clk;

  assign mdio_i = mdio_oe ? mdio_o : (resp_en ? resp_bit : 1'b1);

  mdio_master_regs u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  logic [63:0] bus_bits;
  int rise_cnt = 0, viol = 0, period = 0, cyc = 0, last_rise = -1;
  bit resp_read = 0, resp_present = 0;
  logic [15:0] rdval = '0;
  logic prev_mdc = 0, prev_mdo = 0;

  always @(posedge mdc) begin
    bus_bits = {bus_bits[62:0], mdio_i};
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    if (resp_read && rise_cnt >= 46 && rise_cnt < 64 && resp_present) begin
      resp_en  = 1'b1;
      resp_bit = (rise_cnt == 46) ? 1'b1 : (rise_cnt == 47) ? 1'b0 : rdval[63 - rise_cnt];
    end else begin
      resp_en = 1'b0;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc && mdio_o !== prev_mdo) viol = viol + 1;
    if (mdc && !prev_mdc) begin
      if (last_rise >= 0) period = cyc - last_rise;
      last_rise = cyc;
    end
    prev_mdc = mdc;
    prev_mdo = mdio_o;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 6000; i++) begin
      reg_read(2'd0, r);
      if (!r[0]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_mon();
    rise_cnt = 0; viol = 0; period = 0; last_rise = -1; bus_bits = '0;
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] dv, input logic [1:0] ta, input logic [15:0] pay);
    return {32'hFFFF_FFFF, st, op, p, dv, ta, pay};
  endfunction

  // kind: 0 address, 1 write, 2 read
  task automatic run_op(input int kind, input bit ext, input logic [4:0] p, input logic [4:0] dv,
      input logic [15:0] val, input bit present, input int dvd);
    logic [31:0] r;
    logic [1:0] st, op, ta;
    logic [15:0] pay;
    reg_write(2'd0, (32'(dvd) << 16) | (32'(ext) << 2));
    if (kind != 2) reg_write(2'd1, 32'({p, dv}));
    resp_read = (kind == 2); resp_present = present; rdval = val;
    clear_mon();
    case (kind)
      0: reg_write(2'd2, 32'(val));
      1: reg_write(2'd3, 32'(val));
      default: reg_write(2'd1, 32'h8000 | 32'({p, dv}));
    endcase
    reg_read(2'd3, r);
    chk("R8 data busy at launch", 64'(r[31]), 64'(kind != 0));
    reg_read(2'd0, r);
    chk("R9 busy during frame", 64'(r[0]), 64'd1);
    wait_idle();
    st = ext ? 2'b00 : 2'b01;
    op = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (ext ? 2'b11 : 2'b10);
    ta = (kind == 2) ? (present ? 2'b10 : 2'b11) : 2'b10;
    pay = (kind == 2 && !present) ? 16'hFFFF : val;
    chk("R3 frame length", 64'(rise_cnt), 64'd64);
    chk(kind == 0 ? "R5 address frame" : kind == 1 ? (ext ? "R6 ext write" : "R4 short write") : "R7 read frame",
        bus_bits, exp_frame(st, op, p, dv, ta, pay));
    chk("R2 mdc period", 64'(period), 64'(2 * dvd));
    chk("R12 drive on fall", 64'(viol), 64'd0);
    reg_read(2'd3, r);
    chk("R8 data busy cleared", 64'(r[31]), 64'd0);
    if (kind == 2) begin
      chk("R7 read data", 64'(r[15:0]), 64'(present ? val : 16'hFFFF));
      reg_read(2'd0, r);
      chk("R10 read error", 64'(r[1]), 64'(!present));
    end
    resp_read = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    reg_read(2'd0, r);
    chk("R1 config after reset", 64'(r), 64'd0);
    reg_read(2'd3, r);
    chk("R1 data busy after reset", 64'(r[31]), 64'd0);
    chk("R1 mdc and oe low", 64'({mdc, mdio_oe}), 64'd0);

    run_op(1, 0, 5'h03, 5'h11, 16'hA55A, 0, 2);   // R4
    run_op(0, 1, 5'h1F, 5'h01, 16'h8001, 0, 3);   // R5
    run_op(1, 1, 5'h00, 5'h1E, 16'h0F0F, 0, 1);   // R6
    run_op(2, 0, 5'h0A, 5'h02, 16'hC3E1, 1, 2);   // R7
    run_op(2, 1, 5'h15, 5'h07, 16'h1234, 0, 2);   // R10 no responder
    run_op(2, 1, 5'h15, 5'h07, 16'h7E01, 1, 1);   // R10 cleared by next launch

    // R5: short format address write stores only
    reg_write(2'd0, 32'(2) << 16);
    clear_mon();
    reg_write(2'd2, 32'h0000_4321);
    repeat (40) @(negedge clk);
    chk("R5 no frame in short format", 64'(rise_cnt), 64'd0);
    reg_read(2'd2, r);
    chk("R5 address stored", 64'(r[15:0]), 64'h4321);

    // R11: writes during a frame are ignored
    reg_write(2'd0, (32'(2) << 16) | 32'h4);
    reg_write(2'd1, 32'({5'h09, 5'h0C}));
    clear_mon();
    reg_write(2'd3, 32'h0000_5AA5);
    repeat (30) @(negedge clk);
    reg_write(2'd3, 32'h0000_BEEF);
    reg_write(2'd0, 32'h0);
    reg_write(2'd1, 32'h8000);
    wait_idle();
    chk("R11 frame undisturbed", bus_bits, exp_frame(2'b00, 2'b01, 5'h09, 5'h0C, 2'b10, 16'h5AA5));
    reg_read(2'd3, r);
    chk("R11 data unchanged", 64'(r[15:0]), 64'h5AA5);
    reg_read(2'd0, r);
    chk("R11 config unchanged", 64'(r), (64'd2 << 16) | 64'h4);
    repeat (100) @(negedge clk);
    chk("R11 no extra frame", 64'(rise_cnt), 64'd64);

    for (int i = 0; i < 16; i++) begin
      int k, d;
      bit e;
      e = $urandom_range(1, 0);
      k = e ? $urandom_range(2, 0) : $urandom_range(2, 1);
      d = $urandom_range(3, 1);
      run_op(k, e, 5'($urandom), 5'($urandom), 16'($urandom), bit'($urandom_range(1, 0)), d);
    end

    // R2: zero divider stalls the frame with MDC low
    reg_write(2'd0, 32'h0);
    clear_mon();
    reg_write(2'd3, 32'h0000_1111);
    repeat (200) @(negedge clk);
    chk("R2 zero divider mdc idle", 64'(rise_cnt), 64'd0);
    reg_read(2'd0, r);
    chk("R2 frame stalled busy", 64'(r[0]), 64'd1);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    reg_read(2'd0, r);
    chk("R1 config after second reset", 64'(r), 64'd0);
    chk("R1 oe low after reset", 64'(mdio_oe), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule